// File: doc/BRIEF.md
# Configurable Register Field Cell

This block stores one field of a memory-mapped register and reacts to both the bus and the surrounding hardware. Parameters choose one of nine software access policies and any subset of seven hardware options. The policies are plain read/write, write-one-to-clear, write-one-to-set, read-only, clear-on-read, high-pulse latch, low-pulse latch, write-only and self-clearing write. The hardware options are value input, capture enable, output, clear, set, lock and access notification. The bus side sees only a write strobe with data, a read strobe and the read data. Address decoding stays outside the cell.

A register block instantiates one cell per field. The cell's read data feeds the block's read mux, and its hardware ports connect to the logic that owns the field. Each cycle the cell resolves competing updates in a fixed order. An asserted lock freezes the field. Otherwise hardware clear wins over hardware set, set wins over the software effect, and the software effect wins over hardware capture. The reset value and the reset style (synchronous or asynchronous, either polarity) are parameters. Asynchronous resets are released through a two-stage synchronizer.

Top module: `regfield_cell`

## Requirements
- R1: After reset the field equals RESET_VAL for every reset style. Active-high styles treat rst_in = 1 as reset and active-low styles treat rst_in = 0 as reset. Asynchronous styles reach RESET_VAL within two clock edges of release.
- R2: Under the rw policy, a write strobe loads bus_wdata on the next edge. bus_rdata always shows the stored value, and a read leaves it unchanged.
- R3: Under rw1c, a write clears each bit where bus_wdata is 1 and leaves bits written with 0 untouched. A read has no effect.
- R4: Under rw1s, a write sets each bit where bus_wdata is 1, and bits written with 0 keep their value.
- R5: Under ro, writes do not change the field. Under roc, bus_rdata shows the value during the read strobe cycle, and the field is zero after that edge.
- R6: Under rolh, any 1 on hw_din is ORed into the field and held, and a read clears the field to zero. Under roll, any 0 on hw_din is ANDed into the field and held, and a read sets the field to all ones.
- R7: Under wo and wosc, bus_rdata is always zero while hw_q shows the stored value. Under wosc, a written value stays for one cycle and the field returns to zero on the next edge without a write.
- R8: With the clear option, hw_clr forces all zeros, and with the set option, hw_set forces all ones. When an option is off, its input has no effect.
- R9: With the input option, hw_din is captured on the next edge. With the enable option as well, capture happens only while hw_cap_en is 1.
- R10: With the lock option, hw_lock = 1 keeps the field unchanged against writes, clear, set and capture. When the option is off, hw_lock has no effect.
- R11: When several updates request the same edge, the order is: hw_clr over hw_set, hw_set over the software write, and the software write over hw_din capture.
- R12: With the notify option, acc_wr_pulse is 1 for exactly the one cycle after each write-strobe cycle. acc_rd_pulse behaves the same way for read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset, polarity and timing set by RST_STYLE |
| bus_we | input | 1 | Write strobe for this field |
| bus_wdata | input | WIDTH | Write data |
| bus_re | input | 1 | Read strobe for this field |
| bus_rdata | output | WIDTH | Read data (zero for write-only policies) |
| hw_din | input | WIDTH | Hardware value or pulse input |
| hw_cap_en | input | 1 | Capture enable for hw_din |
| hw_clr | input | 1 | Hardware clear request |
| hw_set | input | 1 | Hardware set request |
| hw_lock | input | 1 | Freeze the field |
| hw_q | output | WIDTH | Field value to hardware (zero if output option off) |
| acc_wr_pulse | output | 1 | One-cycle write notification |
| acc_rd_pulse | output | 1 | One-cycle read notification |

## Verification
Nine cells, one per policy, share a single stimulus stream. One write value therefore separates plain load, clear-by-ones, set-by-ones and ignored writes in the same cycle. Writes of all-zero data show that the one-to-clear and one-to-set policies leave unwritten bits alone. Pulses on hw_din with no read between them show that the latch policies hold their value. A read strobe shows the value before the clear or set takes effect. Stacked requests of clear, set, write and capture are then removed one at a time, and each step exposes the next level of the priority order. Lock is combined with write, clear and capture to show that the field stays frozen, while a cell built without the lock option keeps updating.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

  // Software-visible behaviour of the field
  typedef enum logic [3:0] {
    POL_RW,
    POL_RW1C,
    POL_RW1S,
    POL_RO,
    POL_ROC,
    POL_ROLH,
    POL_ROLL,
    POL_WO,
    POL_WOSC
  } acc_policy_e;

  // Reset flavour of the storage flops
  typedef enum logic [1:0] {
    RST_SYNC_HI,
    RST_SYNC_LO,
    RST_ASYNC_HI,
    RST_ASYNC_LO
  } rst_style_e;

  function automatic bit policy_reads_zero(acc_policy_e p);
    return (p == POL_WO) || (p == POL_WOSC);
  endfunction

  function automatic bit style_is_async(rst_style_e s);
    return (s == RST_ASYNC_HI) || (s == RST_ASYNC_LO);
  endfunction

endpackage

// File: rtl/regfield_rst.sv
module regfield_rst #(
  parameter regfield_pkg::rst_style_e STYLE = regfield_pkg::RST_ASYNC_LO
) (
  input  logic clk,
  input  logic rst_in,
  output logic arst_n,
  output logic srst
);
  localparam bit IS_ASYNC = regfield_pkg::style_is_async(STYLE);

  generate
    if (IS_ASYNC) begin : g_async
      logic       raw_n;
      logic [1:0] rel_q;
      assign raw_n = (STYLE == regfield_pkg::RST_ASYNC_LO) ? rst_in : ~rst_in;
      // assert at once, release after two edges
      always_ff @(posedge clk or negedge raw_n) begin
        if (!raw_n) rel_q <= 2'b00;
        else        rel_q <= {rel_q[0], 1'b1};
      end
      assign arst_n = rel_q[1];
      assign srst   = 1'b0;
    end else begin : g_sync
      assign arst_n = 1'b1;
      assign srst   = (STYLE == regfield_pkg::RST_SYNC_HI) ? rst_in : ~rst_in;
    end
  endgenerate
endmodule

// File: rtl/regfield_flop.sv
module regfield_flop #(
  parameter int unsigned      WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             srst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   q <= RST_VAL;
    else if (srst) q <= RST_VAL;
    else if (en)   q <= d;
  end
endmodule

// File: rtl/regfield_next.sv
module regfield_next #(
  parameter int unsigned              WIDTH  = 8,
  parameter regfield_pkg::acc_policy_e POLICY = regfield_pkg::POL_RW
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             sw_we,
  input  logic [WIDTH-1:0] sw_wdata,
  input  logic             sw_re,
  input  logic [WIDTH-1:0] hw_din,
  input  logic             do_clr,
  input  logic             do_set,
  input  logic             do_cap,
  output logic [WIDTH-1:0] nxt
);
  import regfield_pkg::*;

  logic             sw_hit;
  logic [WIDTH-1:0] sw_val;
  logic             cap_ok;
  logic [WIDTH-1:0] cap_val;
  logic [WIDTH-1:0] hold_val;

  // software effect and capture rule per policy
  always_comb begin
    sw_hit   = 1'b0;
    sw_val   = cur;
    cap_ok   = 1'b1;
    cap_val  = hw_din;
    hold_val = cur;
    case (POLICY)
      POL_RW, POL_WO: begin
        sw_hit = sw_we;
        sw_val = sw_wdata;
      end
      POL_RW1C: begin
        sw_hit = sw_we;
        sw_val = cur & ~sw_wdata;
      end
      POL_RW1S: begin
        sw_hit = sw_we;
        sw_val = cur | sw_wdata;
      end
      POL_ROC: begin
        sw_hit = sw_re;
        sw_val = '0;
      end
      POL_ROLH: begin
        sw_hit  = sw_re;
        sw_val  = '0;
        cap_val = cur | hw_din;
      end
      POL_ROLL: begin
        sw_hit  = sw_re;
        sw_val  = '1;
        cap_val = cur & hw_din;
      end
      POL_WOSC: begin
        sw_hit   = sw_we;
        sw_val   = sw_wdata;
        cap_ok   = 1'b0;
        hold_val = '0;
      end
      default: begin
        sw_hit = 1'b0;
      end
    endcase
  end

  // priority: clear, set, software, capture, hold
  always_comb begin
    if (do_clr)                nxt = '0;
    else if (do_set)           nxt = '1;
    else if (sw_hit)           nxt = sw_val;
    else if (do_cap && cap_ok) nxt = cap_val;
    else                       nxt = hold_val;
  end
endmodule

// File: rtl/regfield_notify.sv
module regfield_notify #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic srst,
  input  logic bus_we,
  input  logic bus_re,
  output logic wr_pulse,
  output logic rd_pulse
);
  logic [1:0] strobe_d;
  logic [1:0] strobe_q;

  assign strobe_d = ENABLE ? {bus_we, bus_re} : 2'b00;

  regfield_flop #(.WIDTH(2), .RST_VAL(2'b00)) u_pulse (
    .clk   (clk),
    .arst_n(arst_n),
    .srst  (srst),
    .en    (1'b1),
    .d     (strobe_d),
    .q     (strobe_q)
  );

  assign wr_pulse = strobe_q[1];
  assign rd_pulse = strobe_q[0];
endmodule

// File: rtl/regfield_cell.sv
module regfield_cell #(
  parameter int unsigned               WIDTH      = 8,
  parameter logic [WIDTH-1:0]          RESET_VAL  = '0,
  parameter regfield_pkg::acc_policy_e POLICY     = regfield_pkg::POL_RW,
  parameter regfield_pkg::rst_style_e  RST_STYLE  = regfield_pkg::RST_ASYNC_LO,
  parameter bit                        OPT_IN     = 1'b0,
  parameter bit                        OPT_EN     = 1'b0,
  parameter bit                        OPT_OUT    = 1'b1,
  parameter bit                        OPT_CLR    = 1'b0,
  parameter bit                        OPT_SET    = 1'b0,
  parameter bit                        OPT_LOCK   = 1'b0,
  parameter bit                        OPT_NOTIFY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_in,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic             bus_re,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] hw_din,
  input  logic             hw_cap_en,
  input  logic             hw_clr,
  input  logic             hw_set,
  input  logic             hw_lock,
  output logic [WIDTH-1:0] hw_q,
  output logic             acc_wr_pulse,
  output logic             acc_rd_pulse
);
  // enable only means something together with the input option
  localparam bit CAP_GATED = OPT_IN && OPT_EN;
  localparam bit RD_ZERO   = regfield_pkg::policy_reads_zero(POLICY);

  logic             arst_n;
  logic             srst;
  logic             lock_eff;
  logic             clr_eff;
  logic             set_eff;
  logic             cap_eff;
  logic             upd_en;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] nxt;

  regfield_rst #(.STYLE(RST_STYLE)) u_rst (
    .clk   (clk),
    .rst_in(rst_in),
    .arst_n(arst_n),
    .srst  (srst)
  );

  assign lock_eff = OPT_LOCK & hw_lock;
  assign clr_eff  = OPT_CLR & hw_clr;
  assign set_eff  = OPT_SET & hw_set;
  assign cap_eff  = OPT_IN & (CAP_GATED ? hw_cap_en : 1'b1);

  regfield_next #(.WIDTH(WIDTH), .POLICY(POLICY)) u_next (
    .cur     (cur_q),
    .sw_we   (bus_we),
    .sw_wdata(bus_wdata),
    .sw_re   (bus_re),
    .hw_din  (hw_din),
    .do_clr  (clr_eff),
    .do_set  (set_eff),
    .do_cap  (cap_eff),
    .nxt     (nxt)
  );

  // lock gates the clock enable of the storage
  assign upd_en = ~lock_eff;

  regfield_flop #(.WIDTH(WIDTH), .RST_VAL(RESET_VAL)) u_val (
    .clk   (clk),
    .arst_n(arst_n),
    .srst  (srst),
    .en    (upd_en),
    .d     (nxt),
    .q     (cur_q)
  );

  generate
    if (RD_ZERO) begin : g_rd_zero
      assign bus_rdata = '0;
    end else begin : g_rd_val
      assign bus_rdata = cur_q;
    end
    if (OPT_OUT) begin : g_out
      assign hw_q = cur_q;
    end else begin : g_no_out
      assign hw_q = '0;
    end
  endgenerate

  regfield_notify #(.ENABLE(OPT_NOTIFY)) u_notify (
    .clk     (clk),
    .arst_n  (arst_n),
    .srst    (srst),
    .bus_we  (bus_we),
    .bus_re  (bus_re),
    .wr_pulse(acc_wr_pulse),
    .rd_pulse(acc_rd_pulse)
  );
endmodule

// File: rtl/regfield_chk.sv
module regfield_chk #(
  parameter int unsigned               WIDTH      = 8,
  parameter regfield_pkg::acc_policy_e POLICY     = regfield_pkg::POL_RW,
  parameter bit                        OPT_CLR    = 1'b0,
  parameter bit                        OPT_SET    = 1'b0,
  parameter bit                        OPT_LOCK   = 1'b0,
  parameter bit                        OPT_NOTIFY = 1'b0
) (
  input logic             clk,
  input logic             arst_n,
  input logic             srst,
  input logic             bus_we,
  input logic [WIDTH-1:0] bus_wdata,
  input logic             bus_re,
  input logic             hw_clr,
  input logic             hw_set,
  input logic             hw_lock,
  input logic [WIDTH-1:0] cur_q,
  input logic             acc_wr_pulse,
  input logic             acc_rd_pulse
);
  import regfield_pkg::*;

  logic lk;
  logic cl;
  logic st;
  assign lk = OPT_LOCK & hw_lock;
  assign cl = OPT_CLR & hw_clr;
  assign st = OPT_SET & hw_set;

  assert_clear_R8: assert property (@(posedge clk) disable iff (!arst_n || srst)
    (cl && !lk) |=> (cur_q == '0));

  assert_set_R8: assert property (@(posedge clk) disable iff (!arst_n || srst)
    (st && !cl && !lk) |=> (cur_q == '1));

  assert_lock_R10: assert property (@(posedge clk) disable iff (!arst_n || srst)
    lk |=> $stable(cur_q));

  assert_ones_clear_R3: assert property (@(posedge clk) disable iff (!arst_n || srst)
    ((POLICY == POL_RW1C) && bus_we && !cl && !st && !lk)
      |=> ((cur_q & $past(bus_wdata)) == '0));

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!arst_n || srst)
    ((POLICY == POL_ROC) && bus_re && !st && !lk) |=> (cur_q == '0));

  assert_self_clear_R7: assert property (@(posedge clk) disable iff (!arst_n || srst)
    ((POLICY == POL_WOSC) && !bus_we && !st && !lk) |=> (cur_q == '0));

  assert_wr_pulse_R12: assert property (@(posedge clk) disable iff (!arst_n || srst)
    (OPT_NOTIFY && bus_we) |=> acc_wr_pulse);

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!arst_n || srst)
    acc_rd_pulse |-> (OPT_NOTIFY && $past(bus_re)));
endmodule

bind regfield_cell regfield_chk #(
  .WIDTH     (WIDTH),
  .POLICY    (POLICY),
  .OPT_CLR   (OPT_CLR),
  .OPT_SET   (OPT_SET),
  .OPT_LOCK  (OPT_LOCK),
  .OPT_NOTIFY(OPT_NOTIFY)
) u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .srst        (srst),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_re      (bus_re),
  .hw_clr      (hw_clr),
  .hw_set      (hw_set),
  .hw_lock     (hw_lock),
  .cur_q       (cur_q),
  .acc_wr_pulse(acc_wr_pulse),
  .acc_rd_pulse(acc_rd_pulse)
);

// File: tb/tb_regfield_cell.sv
`timescale 1ns/1ps
module tb_regfield_cell;
  import regfield_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       rst_hi;
  logic       we, re, cap, clr, set, lock;
  logic [7:0] wdata, din, din_n;

  assign rst_hi = ~rst_n;
  assign din_n  = ~din;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] rd [0:8];
  logic [7:0] hq [0:8];
  logic [8:0] wp, rp;

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'h5A), .POLICY(POL_RW), .RST_STYLE(RST_ASYNC_LO),
    .OPT_IN(1), .OPT_EN(1), .OPT_OUT(1), .OPT_CLR(1), .OPT_SET(1), .OPT_LOCK(1), .OPT_NOTIFY(1)) dut (
    .clk(clk), .rst_in(rst_n), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[0]),
    .hw_din(din), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[0]),
    .acc_wr_pulse(wp[0]), .acc_rd_pulse(rp[0]));

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'hF0), .POLICY(POL_RW1C), .RST_STYLE(RST_SYNC_HI)) dut_rw1c (
    .clk(clk), .rst_in(rst_hi), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[1]),
    .hw_din(din), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[1]),
    .acc_wr_pulse(wp[1]), .acc_rd_pulse(rp[1]));

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'h01), .POLICY(POL_RW1S), .RST_STYLE(RST_SYNC_HI)) dut_rw1s (
    .clk(clk), .rst_in(rst_hi), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[2]),
    .hw_din(din), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[2]),
    .acc_wr_pulse(wp[2]), .acc_rd_pulse(rp[2]));

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'h77), .POLICY(POL_RO), .RST_STYLE(RST_ASYNC_LO)) dut_ro (
    .clk(clk), .rst_in(rst_n), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[3]),
    .hw_din(din), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[3]),
    .acc_wr_pulse(wp[3]), .acc_rd_pulse(rp[3]));

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'h00), .POLICY(POL_ROC), .RST_STYLE(RST_ASYNC_LO),
    .OPT_IN(1), .OPT_EN(1)) dut_roc (
    .clk(clk), .rst_in(rst_n), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[4]),
    .hw_din(din), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[4]),
    .acc_wr_pulse(wp[4]), .acc_rd_pulse(rp[4]));

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'h00), .POLICY(POL_ROLH), .RST_STYLE(RST_SYNC_LO),
    .OPT_IN(1)) dut_rolh (
    .clk(clk), .rst_in(rst_n), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[5]),
    .hw_din(din), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[5]),
    .acc_wr_pulse(wp[5]), .acc_rd_pulse(rp[5]));

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'hFF), .POLICY(POL_ROLL), .RST_STYLE(RST_ASYNC_HI),
    .OPT_IN(1)) dut_roll (
    .clk(clk), .rst_in(rst_hi), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[6]),
    .hw_din(din_n), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[6]),
    .acc_wr_pulse(wp[6]), .acc_rd_pulse(rp[6]));

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'h00), .POLICY(POL_WO), .RST_STYLE(RST_ASYNC_LO)) dut_wo (
    .clk(clk), .rst_in(rst_n), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[7]),
    .hw_din(din), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[7]),
    .acc_wr_pulse(wp[7]), .acc_rd_pulse(rp[7]));

  regfield_cell #(.WIDTH(8), .RESET_VAL(8'h00), .POLICY(POL_WOSC), .RST_STYLE(RST_ASYNC_LO)) dut_wosc (
    .clk(clk), .rst_in(rst_n), .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rd[8]),
    .hw_din(din), .hw_cap_en(cap), .hw_clr(clr), .hw_set(set), .hw_lock(lock), .hw_q(hq[8]),
    .acc_wr_pulse(wp[8]), .acc_rd_pulse(rp[8]));

  // observation points
  localparam int S_RD = 0, S_HQ = 1, S_WP = 2, S_RP = 3, S_RW1C = 4, S_RW1S = 5, S_RO = 6,
                 S_ROC = 7, S_ROLH = 8, S_ROLL = 9, S_WO_RD = 10, S_WO_Q = 11,
                 S_WOSC_RD = 12, S_WOSC_Q = 13;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      S_RD:      return rd[0];
      S_HQ:      return hq[0];
      S_WP:      return {7'b0, wp[0]};
      S_RP:      return {7'b0, rp[0]};
      S_RW1C:    return rd[1];
      S_RW1S:    return rd[2];
      S_RO:      return rd[3];
      S_ROC:     return rd[4];
      S_ROLH:    return rd[5];
      S_ROLL:    return rd[6];
      S_WO_RD:   return rd[7];
      S_WO_Q:    return hq[7];
      S_WOSC_RD: return rd[8];
      S_WOSC_Q:  return hq[8];
      default:   return 8'hxx;
    endcase
  endfunction

  typedef struct {
    int         due;
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    cyc;
  int    checks;
  int    bad;
  bit    done;

  // monitor: compares queued expectations in the low clock phase
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      #2;
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s point=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic drive(input logic w, input logic [7:0] wd, input logic r, input logic [7:0] d,
                       input logic c, input logic cl, input logic st, input logic lk);
    @(negedge clk);
    #1;
    we = w; wdata = wd; re = r; din = d; cap = c; clr = cl; set = st; lock = lk;
  endtask

  task automatic idle();
    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic expect_now(input int sel, input logic [7:0] e, input string tag);
    item_t it;
    it = '{cyc, sel, e, tag};
    sb_q.push_back(it);
  endtask

  task automatic expect_next(input int sel, input logic [7:0] e, input string tag);
    item_t it;
    it = '{cyc + 1, sel, e, tag};
    sb_q.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    cyc = 0; checks = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0;
    we = 0; wdata = 0; re = 0; din = 0; cap = 0; clr = 0; set = 0; lock = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle();

    // R1: reset values, all styles
    expect_now(S_RD,     8'h5A, "R1 rw async-lo");
    expect_now(S_RW1C,   8'hF0, "R1 rw1c sync-hi");
    expect_now(S_RW1S,   8'h01, "R1 rw1s sync-hi");
    expect_now(S_RO,     8'h77, "R1 ro");
    expect_now(S_ROC,    8'h00, "R1 roc");
    expect_now(S_ROLH,   8'h00, "R1 rolh sync-lo");
    expect_now(S_ROLL,   8'hFF, "R1 roll async-hi");
    expect_now(S_WO_Q,   8'h00, "R1 wo");
    expect_now(S_WOSC_Q, 8'h00, "R1 wosc");

    // write A5 to all cells
    drive(1'b1, 8'hA5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_next(S_RD,     8'hA5, "R2 rw load");
    expect_next(S_HQ,     8'hA5, "R2 rw hw view");
    expect_next(S_WP,     8'h01, "R12 write pulse");
    expect_next(S_RW1C,   8'h50, "R3 clear by ones");
    expect_next(S_RW1S,   8'hA5, "R4 set by ones");
    expect_next(S_RO,     8'h77, "R5 ro ignores write");
    expect_next(S_WO_RD,  8'h00, "R7 wo reads zero");
    expect_next(S_WO_Q,   8'hA5, "R7 wo hw value");
    expect_next(S_WOSC_Q, 8'hA5, "R7 wosc written");

    idle();
    expect_next(S_WOSC_Q,  8'h00, "R7 wosc self clear");
    expect_next(S_WOSC_RD, 8'h00, "R7 wosc reads zero");
    expect_next(S_WP,      8'h00, "R12 write pulse one cycle");
    expect_next(S_RD,      8'hA5, "R2 rw hold");

    drive(1'b1, 8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_next(S_RW1C,  8'h40, "R3 single bit clear");
    expect_next(S_RW1S,  8'hB5, "R4 single bit set");
    expect_next(S_WO_RD, 8'h00, "R7 wo reads zero");

    drive(1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_next(S_RW1C, 8'h40, "R3 zeros no effect");
    expect_next(S_RW1S, 8'hB5, "R4 zeros no effect");
    expect_next(S_RD,   8'h00, "R2 rw load zero");

    // hw input with enable low, latches see pulses
    drive(1'b0, 8'h00, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_next(S_RD,   8'h00, "R9 capture gated off");
    expect_next(S_ROC,  8'h00, "R9 roc capture gated off");
    expect_next(S_ROLH, 8'h3C, "R6 rolh latch high");
    expect_next(S_ROLL, 8'hC3, "R6 roll latch low");

    drive(1'b0, 8'h00, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_next(S_RD,  8'h3C, "R9 capture enabled");
    expect_next(S_ROC, 8'h3C, "R9 roc capture enabled");

    idle();
    expect_next(S_ROLH, 8'h3C, "R6 rolh holds");
    expect_next(S_ROLL, 8'hC3, "R6 roll holds");

    // read strobe
    drive(1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_now(S_RD,    8'h3C, "R2 rw read value");
    expect_now(S_ROC,   8'h3C, "R5 roc value during read");
    expect_now(S_ROLH,  8'h3C, "R6 rolh value during read");
    expect_now(S_ROLL,  8'hC3, "R6 roll value during read");
    expect_next(S_RP,   8'h01, "R12 read pulse");
    expect_next(S_ROC,  8'h00, "R5 roc cleared by read");
    expect_next(S_ROLH, 8'h00, "R6 rolh cleared by read");
    expect_next(S_ROLL, 8'hFF, "R6 roll set by read");
    expect_next(S_RW1C, 8'h40, "R3 read no effect");
    expect_next(S_RD,   8'h3C, "R2 read no effect");

    idle();
    expect_next(S_RP, 8'h00, "R12 read pulse one cycle");

    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_next(S_RD,   8'h00, "R8 hw clear");
    expect_next(S_RW1C, 8'h40, "R8 clear ignored without option");

    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_next(S_RD, 8'hFF, "R8 hw set");

    // priority ladder
    drive(1'b1, 8'h12, 1'b0, 8'h34, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_next(S_RD, 8'h00, "R11 clear over all");
    drive(1'b1, 8'h12, 1'b0, 8'h34, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_next(S_RD, 8'hFF, "R11 set over write");
    drive(1'b1, 8'h12, 1'b0, 8'h34, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_next(S_RD,     8'h12, "R11 write over capture");
    expect_next(S_WOSC_Q, 8'h12, "R7 wosc written again");
    idle();
    expect_next(S_WOSC_Q, 8'h00, "R7 wosc self clear again");
    expect_next(S_RD,     8'h12, "R2 rw hold");

    // lock
    drive(1'b1, 8'h99, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_next(S_RD,   8'h12, "R10 lock blocks write");
    expect_next(S_RW1S, 8'hBF, "R10 lock ignored without option");
    expect_next(S_WO_Q, 8'h99, "R7 wo hw value");
    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    expect_next(S_RD, 8'h12, "R10 lock blocks clear");
    drive(1'b0, 8'h00, 1'b0, 8'h77, 1'b1, 1'b0, 1'b0, 1'b1);
    expect_next(S_RD,  8'h12, "R10 lock blocks capture");
    expect_next(S_ROC, 8'h77, "R9 roc capture");
    idle();
    expect_next(S_RD, 8'h12, "R10 after unlock");

    repeat (3) idle();
    if (sb_q.size() != 0) begin
      checks++;
      bad++;
      $display("FAIL scoreboard drain actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule